// File: doc/BRIEF.md
# BMC Preamble and Hard-Reset Detector

This block sits at the front of a biphase-mark receiver and examines the stream of measured intervals between line edges at the start of a reception. Each interval is reduced to a single flag, short or long, and the flag enters a 32-entry history. When that history equals one of two fixed signatures, the block reports one of two events. The first is the end of the alternating preamble, where the first sync symbol begins. The second is a hard-reset ordered set. The block also reports the edge index at which the match occurred, so the bit decoder that follows knows where to resume.

A controller arms the detector when a reception starts. Interval measurements then arrive one per `ivl_valid` strobe. The detector reports exactly one outcome per arming: sync found, hard reset, or failure. Failure happens when the edge budget runs out or the receive timeout strobe fires. After reporting, the detector is idle until it is armed again.

Top module: `bmc_preamble_det`

## Requirements
- R1: After reset, and whenever the detector is not armed, all three outcome pulses stay low and interval strobes and timeouts cause no outcome.
- R2: An interval of at most SHORT_MAX ticks (default 6) enters the history as 1 and a longer one as 0. The new flag enters at bit 31, and older flags move one place toward bit 0.
- R3: When the history becomes 0x36DB6DB6, `sync_pulse` is raised. `hit_edge` then carries the index of the edge before the one that ended the matching interval. Edges are numbered from 0 at the first captured edge, so the first interval after arming ends at edge 1.
- R4: When the history becomes 0xF33F3F3F, `hreset_pulse` is raised, with `hit_edge` numbered as in R3.
- R5: If the interval ending at edge MAX_EDGES-2 (default 856) produces no match, `fail_pulse` is raised for that interval.
- R6: A receive timeout strobe while armed raises `fail_pulse`. A match from an interval sampled in the same cycle takes precedence and is reported instead.
- R7: Exactly one outcome is reported per arming. Later intervals and timeouts produce nothing until `arm` is asserted again.
- R8: Asserting `arm` clears the history to zero and restarts edge numbering, even in the middle of a search. Flags taken before re-arming never contribute to a match.
- R9: Each outcome is a single-cycle pulse, and at most one of the three pulses is high in any cycle.
- R10: An outcome appears on the outputs two clock edges after the edge that samples the interval or timeout that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a new search; clears the history and edge numbering |
| ivl_valid | input | 1 | An interval measurement is presented this cycle |
| ivl_ticks | input | TICK_W | Length of the interval in timer ticks |
| rx_timeout | input | 1 | Receive timeout strobe |
| sync_pulse | output | 1 | Preamble end / first sync symbol found |
| hreset_pulse | output | 1 | Hard-reset ordered set found |
| fail_pulse | output | 1 | Search abandoned (edge budget or timeout) |
| hit_edge | output | IDX_W | Edge index reported with a sync or hard-reset match |

## Verification
Every outcome is due exactly two edges after the edge that samples its cause. The first edge shifts the history and loads the check stage, and the second registers the pulse. When the bench drives an interval or timeout, it records the cycle number and pushes the expected outcome with a due cycle two later. The monitor reads the outputs on the falling edge and compares the pulse kind, the edge index and the arrival cycle against that entry. A pulse that arrives early, arrives late or has no entry is reported against the requirement concerned.

// File: rtl/bmc_det_pkg.sv
package bmc_det_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HUNT = 1'b1
  } det_state_t;

  localparam int unsigned HIST_W_DEF   = 32;
  localparam logic [31:0] SYNC_SIG_DEF = 32'h36DB_6DB6;
  localparam logic [31:0] HRST_SIG_DEF = 32'hF33F_3F3F;

endpackage

// File: rtl/bmc_ivl_class.sv
// Reduces one interval length to a short/long flag.
module bmc_ivl_class #(
  parameter int unsigned TICK_W    = 8,
  parameter int unsigned SHORT_MAX = 6
) (
  input  logic [TICK_W-1:0] ticks,
  output logic              is_short
);
  localparam logic [TICK_W-1:0] LIMIT = TICK_W'(SHORT_MAX);

  always_comb is_short = (ticks <= LIMIT);
endmodule

// File: rtl/bmc_hist_reg.sv
// Flag history: newest flag at the top bit, oldest falls off bit 0.
module bmc_hist_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist <= '0;
    end else if (shift) begin
      hist <= {bit_in, hist[W-1:1]};
    end
  end
endmodule

// File: rtl/bmc_sig_match.sv
// Equality against one fixed signature.
module bmc_sig_match #(
  parameter int unsigned  W   = 32,
  parameter logic [W-1:0] SIG = '0
) (
  input  logic [W-1:0] hist,
  output logic         hit
);
  always_comb hit = (hist == SIG);
endmodule

// File: rtl/bmc_edge_ctr.sv
// Edge index of the interval currently being taken; starts at 1 on load.
module bmc_edge_ctr #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned LAST  = 856
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             inc,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  localparam logic [IDX_W-1:0] LAST_V = IDX_W'(LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (load) begin
      idx <= IDX_W'(1);
    end else if (inc) begin
      idx <= idx + IDX_W'(1);
    end
  end

  always_comb at_last = (idx == LAST_V);
endmodule

// File: rtl/bmc_preamble_det.sv
module bmc_preamble_det
  import bmc_det_pkg::*;
#(
  parameter int unsigned       TICK_W    = 8,
  parameter int unsigned       SHORT_MAX = 6,
  parameter int unsigned       HIST_W    = HIST_W_DEF,
  parameter logic [HIST_W-1:0] SYNC_SIG  = HIST_W'(SYNC_SIG_DEF),
  parameter logic [HIST_W-1:0] HRST_SIG  = HIST_W'(HRST_SIG_DEF),
  parameter int unsigned       MAX_EDGES = 858,
  localparam int unsigned      IDX_W     = $clog2(MAX_EDGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              ivl_valid,
  input  logic [TICK_W-1:0] ivl_ticks,
  input  logic              rx_timeout,
  output logic              sync_pulse,
  output logic              hreset_pulse,
  output logic              fail_pulse,
  output logic [IDX_W-1:0]  hit_edge
);
  localparam int unsigned LAST_IDX = MAX_EDGES - 2;

  det_state_t        state_q;
  logic              hunting;
  logic              take;
  logic              short_flag;
  logic [HIST_W-1:0] hist;
  logic              sync_hit;
  logic              hrst_hit;
  logic [IDX_W-1:0]  idx;
  logic              at_last;

  // check stage: one cycle behind the history shift
  logic              chk_v;
  logic              chk_to;
  logic              chk_last;
  logic [IDX_W-1:0]  chk_idx;

  always_comb begin
    hunting = (state_q == ST_HUNT);
    take    = hunting && ivl_valid && !arm;
  end

  bmc_ivl_class #(.TICK_W(TICK_W), .SHORT_MAX(SHORT_MAX)) u_class (
    .ticks    (ivl_ticks),
    .is_short (short_flag)
  );

  bmc_hist_reg #(.W(HIST_W)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .clr    (arm),
    .shift  (take),
    .bit_in (short_flag),
    .hist   (hist)
  );

  bmc_sig_match #(.W(HIST_W), .SIG(SYNC_SIG)) u_sync_cmp (
    .hist (hist),
    .hit  (sync_hit)
  );

  bmc_sig_match #(.W(HIST_W), .SIG(HRST_SIG)) u_hrst_cmp (
    .hist (hist),
    .hit  (hrst_hit)
  );

  bmc_edge_ctr #(.IDX_W(IDX_W), .LAST(LAST_IDX)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (arm),
    .inc     (take),
    .idx     (idx),
    .at_last (at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      chk_v        <= 1'b0;
      chk_to       <= 1'b0;
      chk_last     <= 1'b0;
      chk_idx      <= '0;
      sync_pulse   <= 1'b0;
      hreset_pulse <= 1'b0;
      fail_pulse   <= 1'b0;
      hit_edge     <= '0;
    end else begin
      chk_v        <= take;
      chk_to       <= hunting && rx_timeout && !arm;
      chk_last     <= at_last;
      chk_idx      <= idx;
      sync_pulse   <= 1'b0;
      hreset_pulse <= 1'b0;
      fail_pulse   <= 1'b0;
      if (arm) begin
        state_q <= ST_HUNT;
      end else if (hunting) begin
        if (chk_v && sync_hit) begin
          sync_pulse <= 1'b1;
          hit_edge   <= chk_idx - IDX_W'(1);
          state_q    <= ST_IDLE;
        end else if (chk_v && hrst_hit) begin
          hreset_pulse <= 1'b1;
          hit_edge     <= chk_idx - IDX_W'(1);
          state_q      <= ST_IDLE;
        end else if ((chk_v && chk_last) || chk_to) begin
          fail_pulse <= 1'b1;
          state_q    <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/bmc_preamble_det_chk.sv
module bmc_preamble_det_chk #(
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned MAX_EDGES = 858
) (
  input logic             clk,
  input logic             rst,
  input logic             arm,
  input logic             sync_pulse,
  input logic             hreset_pulse,
  input logic             fail_pulse,
  input logic [IDX_W-1:0] hit_edge
);
  logic any_out;
  logic live;

  always_comb any_out = sync_pulse || hreset_pulse || fail_pulse;

  // independent view of whether an arming is still awaiting its outcome
  always_ff @(posedge clk) begin
    if (rst)          live <= 1'b0;
    else if (arm)     live <= 1'b1;
    else if (any_out) live <= 1'b0;
  end

  p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sync_pulse, hreset_pulse, fail_pulse}));

  p_single_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    any_out |=> !any_out);

  p_one_per_arm_r7: assert property (@(posedge clk) disable iff (rst)
    any_out |-> live);

  // a sync match needs at least 31 intervals after a cleared history (R3)
  p_sync_edge_r3: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> (hit_edge >= IDX_W'(30)) && (hit_edge <= IDX_W'(MAX_EDGES - 3)));

  // a hard-reset match needs all 32 entries filled (R4)
  p_hrst_edge_r4: assert property (@(posedge clk) disable iff (rst)
    hreset_pulse |-> (hit_edge >= IDX_W'(31)) && (hit_edge <= IDX_W'(MAX_EDGES - 3)));
endmodule

bind bmc_preamble_det bmc_preamble_det_chk #(
  .IDX_W     (IDX_W),
  .MAX_EDGES (MAX_EDGES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .arm          (arm),
  .sync_pulse   (sync_pulse),
  .hreset_pulse (hreset_pulse),
  .fail_pulse   (fail_pulse),
  .hit_edge     (hit_edge)
);

// File: tb/bmc_preamble_det_tb.sv
module bmc_preamble_det_tb;
  localparam int TICK_W    = 8;
  localparam int MAX_EDGES = 858;
  localparam int IDX_W     = $clog2(MAX_EDGES);
  localparam logic [31:0] SYNC = 32'h36DB_6DB6;
  localparam logic [31:0] HRST = 32'hF33F_3F3F;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              arm = 1'b0;
  logic              ivl_valid = 1'b0;
  logic [TICK_W-1:0] ivl_ticks = '0;
  logic              rx_timeout = 1'b0;
  logic              sync_pulse, hreset_pulse, fail_pulse;
  logic [IDX_W-1:0]  hit_edge;

  bmc_preamble_det u_dut (
    .clk (clk), .rst (rst), .arm (arm),
    .ivl_valid (ivl_valid), .ivl_ticks (ivl_ticks), .rx_timeout (rx_timeout),
    .sync_pulse (sync_pulse), .hreset_pulse (hreset_pulse),
    .fail_pulse (fail_pulse), .hit_edge (hit_edge)
  );

  always #5 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  // scoreboard: kind 0 sync, 1 hard reset, 2 fail
  int     q_kind[$];
  int     q_edge[$];
  longint q_due[$];
  string  q_req[$];

  // reference state, from the requirements
  logic [31:0] m_hist = '0;
  int          m_idx  = 1;
  bit          m_hunt = 0;

  function automatic string kname(int k);
    return (k == 0) ? "sync" : (k == 1) ? "hreset" : "fail";
  endfunction

  task automatic push(int kind, int edge_n, string req);
    q_kind.push_back(kind);
    q_edge.push_back(edge_n);
    q_due.push_back(cyc + 2);
    q_req.push_back(req);
  endtask

  task automatic do_arm();
    @(negedge clk);
    arm = 1'b1; ivl_valid = 1'b0; rx_timeout = 1'b0;
    m_hist = '0; m_idx = 1; m_hunt = 1;
  endtask

  task automatic send_ivl(int ticks, bit to, string req);
    @(negedge clk);
    arm = 1'b0; ivl_valid = 1'b1; ivl_ticks = TICK_W'(ticks); rx_timeout = to;
    if (m_hunt) begin
      m_hist = {(ticks <= 6), m_hist[31:1]};
      if (m_hist == SYNC) begin
        push(0, m_idx - 1, req); m_hunt = 0;
      end else if (m_hist == HRST) begin
        push(1, m_idx - 1, req); m_hunt = 0;
      end else if (m_idx == MAX_EDGES - 2) begin
        push(2, 0, req); m_hunt = 0;
      end
      m_idx++;
    end
    if (to && m_hunt) begin
      push(2, 0, req); m_hunt = 0;
    end
  endtask

  task automatic send_timeout(string req);
    @(negedge clk);
    arm = 1'b0; ivl_valid = 1'b0; rx_timeout = 1'b1;
    if (m_hunt) begin push(2, 0, req); m_hunt = 0; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      arm = 1'b0; ivl_valid = 1'b0; rx_timeout = 1'b0;
    end
  endtask

  task automatic send_bits(logic [31:0] w, int nbits, int first, int sh, int lg, string req);
    for (int i = first; i < first + nbits; i++) send_ivl(w[i] ? sh : lg, 0, req);
  endtask

  task automatic preamble(int groups, int sh, int lg, string req);
    for (int g = 0; g < groups; g++) begin
      send_ivl(lg, 0, req); send_ivl(sh, 0, req); send_ivl(sh, 0, req);
    end
  endtask

  task automatic check_drained(string req);
    idle(4);
    checks++;
    if (q_kind.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d outcomes still pending, expected 0", req, q_kind.size());
      q_kind.delete(); q_edge.delete(); q_due.delete(); q_req.delete();
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      int n;
      int k;
      n = int'(sync_pulse) + int'(hreset_pulse) + int'(fail_pulse);
      while (q_due.size() != 0 && q_due[0] < cyc) begin
        checks++; fails++;
        $display("FAIL %s (R10): %s missing, due cycle %0d, now %0d",
                 q_req[0], kname(q_kind[0]), q_due[0], cyc);
        void'(q_kind.pop_front()); void'(q_edge.pop_front());
        void'(q_due.pop_front());  void'(q_req.pop_front());
      end
      if (n > 1) begin
        checks++; fails++;
        $display("FAIL R9: %0d outcome pulses high together, expected at most 1", n);
      end else if (n == 1) begin
        k = sync_pulse ? 0 : hreset_pulse ? 1 : 2;
        checks++;
        if (q_kind.size() == 0) begin
          fails++;
          $display("FAIL R7: unexpected %s at cycle %0d, expected none", kname(k), cyc);
        end else begin
          if (k != q_kind[0] || q_due[0] != cyc ||
              (k != 2 && int'(hit_edge) != q_edge[0])) begin
            fails++;
            $display("FAIL %s: got %s edge %0d cycle %0d, expected %s edge %0d cycle %0d",
                     q_req[0], kname(k), hit_edge, cyc,
                     kname(q_kind[0]), q_edge[0], q_due[0]);
          end
          void'(q_kind.pop_front()); void'(q_edge.pop_front());
          void'(q_due.pop_front());  void'(q_req.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    idle(2);
    // R1: reset state
    checks++;
    if ({sync_pulse, hreset_pulse, fail_pulse} != 3'b000 || hit_edge != '0) begin
      fails++;
      $display("FAIL R1: outputs %b edge %0d after reset, expected 000 edge 0",
               {sync_pulse, hreset_pulse, fail_pulse}, hit_edge);
    end
    // R1: not armed, a full sync signature and a timeout are ignored
    send_bits(SYNC, 32, 0, 3, 20, "R1");
    send_timeout("R1");
    check_drained("R1");

    // R2 / R3: preamble with boundary ticks 6 (short) and 7 (long), then two longs
    do_arm();
    preamble(12, 6, 7, "R2");
    send_ivl(7, 0, "R2"); send_ivl(7, 0, "R2");
    check_drained("R2");

    // R4: hard-reset signature right after arming (edge 31)
    do_arm();
    send_bits(HRST, 32, 0, 1, 200, "R4");
    check_drained("R4");

    // R3: noise first, then preamble and sync, at a later edge
    do_arm();
    for (int i = 0; i < 45; i++) send_ivl(((i * 7) % 5 == 0) ? 4 : 12, 0, "R3");
    preamble(11, 2, 9, "R3");
    send_ivl(9, 0, "R3"); send_ivl(9, 0, "R3");
    check_drained("R3");

    // R6: timeout during search
    do_arm();
    preamble(2, 4, 8, "R6");
    send_timeout("R6");
    check_drained("R6");

    // R6: timeout in the same cycle as the matching interval, sync wins
    do_arm();
    preamble(12, 5, 8, "R6");
    send_ivl(8, 0, "R6"); send_ivl(8, 1, "R6");
    check_drained("R6");

    // R7: outcome already given, more matches and timeouts ignored
    preamble(12, 5, 8, "R7");
    send_ivl(8, 0, "R7"); send_ivl(8, 0, "R7");
    send_bits(HRST, 32, 0, 1, 30, "R7");
    send_timeout("R7");
    check_drained("R7");

    // R8: re-arm mid-search clears history; split sync must not match
    do_arm();
    send_bits(SYNC, 16, 0, 3, 10, "R8");
    do_arm();
    send_bits(SYNC, 16, 16, 3, 10, "R8");
    idle(2);
    send_timeout("R8");
    check_drained("R8");

    // R8: edge numbering restarts after re-arm
    do_arm();
    for (int i = 0; i < 20; i++) send_ivl(10, 0, "R8");
    do_arm();
    send_bits(HRST, 32, 0, 2, 10, "R8");
    check_drained("R8");

    // R5: only long intervals, budget exhausted at edge 856
    do_arm();
    for (int i = 0; i < MAX_EDGES; i++) send_ivl(15, 0, "R5");
    check_drained("R5");

    // R9 / R10: back-to-back arm and sync, pulse width checked by monitor
    do_arm();
    preamble(11, 1, 255, "R10");
    send_ivl(255, 0, "R10"); send_ivl(255, 0, "R10");
    check_drained("R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule